// File: doc/BRIEF.md
# Delay-Line Thermometer Control Generator

This block turns a binary delay setting into the two per-cell control words needed by a NAND-based digitally controlled delay line of `CELLS` cells. The first word, `s_o`, is a thermometer word that selects how many cells the edge passes through. The second word, `t_o`, is one-cold: it holds a single zero that marks the cell where the edge turns back.

A short registered driving stage keeps the two words in step. After a new setting is sampled, `t_o` moves one cycle before `s_o`, so the turning point is already in place when the thermometer boundary shifts. This keeps jumps of several steps from producing intermediate states on the delay line.

The constant level held by the last lower cell depends on whether the line is built in the inverting or the non-inverting arrangement. A parameter selects that level, and the block drives it out for the cell array to use.

Top module: `dly_ctrl_gen`

## Requirements
- R1: One cycle after `code_i` is sampled, `s_o[i]` is 0 for every i below the clamped code and 1 for every i at or above it. For example, code 2 gives bits 0 and 1 low and bits 2 and up high.
- R2: `t_o` has exactly one zero bit, at index clamped code + 1. Every other bit of the `CELLS+1` bits is 1.
- R3: `t_o` reflects the code sampled on the immediately preceding rising edge.
- R4: `s_o` reflects the code sampled two rising edges earlier. A changed code therefore reaches `t_o` one cycle before it reaches `s_o`, whatever the size of the jump.
- R5: While `rst` is high and on the cycle after it falls, `s_o` is all ones and `t_o` is all ones except bit 1, which is the encoding for code 0.
- R6: A `code_i` value of `CELLS` or above is treated as `CELLS-1`.
- R7: `tie_o` is 1 when `INVERT` is 0 (non-inverting line) and 0 when `INVERT` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both control registers |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | $clog2(CELLS)+1 | Binary delay setting; values of CELLS and above saturate |
| s_o | output | CELLS | Thermometer control word |
| t_o | output | CELLS+1 | One-cold turning-cell control word |
| tie_o | output | 1 | Constant level for the last lower cell |

## Verification
The properties assume only that `code_i` holds a known value at every rising edge. They do not assume the code is in range, because out-of-range values are part of the defined behaviour.

The stimulus changes `code_i` only half a cycle away from the rising edge. It mixes random values across the full input width with directed jumps between the ends of the range, and with values above `CELLS-1`. Because of this, the two-cycle lag of `s_o` behind `t_o` is exercised on multi-step changes, reversals and saturated codes.

// File: rtl/dly_ctrl_pkg.sv
package dly_ctrl_pkg;

  // Level held by the terminating lower cell for each line arrangement.
  function automatic logic tie_level(input bit invert);
    return invert ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/dly_code_clamp.sv
module dly_code_clamp #(
  parameter int CODE_W = 4,
  parameter int IDX_W  = 3,
  parameter int CELLS  = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [CODE_W-1:0] LIMIT = CODE_W'(CELLS - 1);

  always_comb begin
    if (code_i > LIMIT) idx_o = IDX_W'(CELLS - 1);
    else                idx_o = code_i[IDX_W-1:0];
  end
endmodule

// File: rtl/dly_code_decode.sv
module dly_code_decode #(
  parameter int CELLS = 8,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [CELLS-1:0] s_n,
  output logic [CELLS:0]   t_n
);
  logic [IDX_W:0] turn;
  assign turn = {1'b0, idx_i} + (IDX_W+1)'(1);

  for (genvar i = 0; i < CELLS; i++) begin : g_therm
    assign s_n[i] = (IDX_W'(i) >= idx_i);
  end

  for (genvar j = 0; j <= CELLS; j++) begin : g_cold
    assign t_n[j] = ((IDX_W+1)'(j) != turn);
  end
endmodule

// File: rtl/dly_drive_stage.sv
module dly_drive_stage #(
  parameter int              W       = 8,
  parameter int              DEPTH   = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[k] <= RST_VAL;
        else     pipe[k] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[k] <= RST_VAL;
        else     pipe[k] <= pipe[k-1];
      end
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/dly_ctrl_gen.sv
module dly_ctrl_gen #(
  parameter int CELLS  = 8,
  parameter bit INVERT = 1'b0,
  localparam int IDX_W  = $clog2(CELLS),
  localparam int CODE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic [CELLS-1:0]  s_o,
  output logic [CELLS:0]    t_o,
  output logic              tie_o
);
  localparam logic [CELLS-1:0] S_RST = '1;
  localparam logic [CELLS:0]   T_RST = ~((CELLS+1)'(2));

  logic [IDX_W-1:0] idx;
  logic [CELLS-1:0] s_n;
  logic [CELLS:0]   t_n;

  dly_code_clamp #(.CODE_W(CODE_W), .IDX_W(IDX_W), .CELLS(CELLS)) u_clamp (
    .code_i(code_i), .idx_o(idx)
  );

  dly_code_decode #(.CELLS(CELLS), .IDX_W(IDX_W)) u_dec (
    .idx_i(idx), .s_n(s_n), .t_n(t_n)
  );

  // Turning word: one register, straight through.
  dly_drive_stage #(.W(CELLS+1), .DEPTH(1), .RST_VAL(T_RST)) u_t_reg (
    .clk(clk), .rst(rst), .d(t_n), .q(t_o)
  );

  // Thermometer word: one extra register so it trails the turning word.
  dly_drive_stage #(.W(CELLS), .DEPTH(2), .RST_VAL(S_RST)) u_s_reg (
    .clk(clk), .rst(rst), .d(s_n), .q(s_o)
  );

  assign tie_o = dly_ctrl_pkg::tie_level(INVERT);
endmodule

// File: rtl/dly_ctrl_gen_chk.sv
module dly_ctrl_gen_chk #(
  parameter int CELLS  = 8,
  parameter bit INVERT = 1'b0,
  localparam int IDX_W  = $clog2(CELLS),
  localparam int CODE_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_i,
  input logic [CELLS-1:0]  s_o,
  input logic [CELLS:0]    t_o,
  input logic              tie_o
);
  function automatic logic [CELLS:0] t_for(input logic [CODE_W-1:0] c);
    int v;
    logic [CELLS:0] r;
    v = (int'(c) > CELLS - 1) ? CELLS - 1 : int'(c);
    r = '1;
    r[v+1] = 1'b0;
    return r;
  endfunction

  function automatic logic [CELLS-1:0] s_from_t(input logic [CELLS:0] t);
    int z;
    logic [CELLS-1:0] r;
    z = 1;
    for (int j = 0; j <= CELLS; j++) if (!t[j]) z = j;
    for (int i = 0; i < CELLS; i++) r[i] = (i >= z - 1);
    return r;
  endfunction

  AST_T_ONE_COLD: assert property (@(posedge clk) disable iff (rst)
    $countones(t_o) == CELLS); // R2
  AST_T_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> t_o == t_for($past(code_i))); // R3
  AST_S_TRAILS_T: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> s_o == s_from_t($past(t_o))); // R4
  AST_S_THERMO: assert property (@(posedge clk) disable iff (rst)
    s_o[CELLS-1] && ((((~s_o) + 1'b1) & (~s_o)) == '0)); // R1
  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (s_o == '1) && (t_o == ~((CELLS+1)'(2)))); // R5
  AST_TIE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    tie_o == !INVERT); // R7
endmodule

bind dly_ctrl_gen dly_ctrl_gen_chk #(.CELLS(CELLS), .INVERT(INVERT)) u_chk (.*);

// File: tb/dly_ctrl_gen_tb.sv
module dly_ctrl_gen_tb;
  localparam int CELLS  = 8;
  localparam int IDX_W  = $clog2(CELLS);
  localparam int CODE_W = IDX_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CODE_W-1:0] code_i = '0;
  logic [CELLS-1:0]  s_o;
  logic [CELLS:0]    t_o;
  logic              tie_o;

  int checks = 0;
  int fails  = 0;
  int cur = 0;
  int prev = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dly_ctrl_gen #(.CELLS(CELLS), .INVERT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .code_i(code_i), .s_o(s_o), .t_o(t_o), .tie_o(tie_o)
  );

  function automatic int sat(input int c);
    return (c > CELLS - 1) ? CELLS - 1 : c;
  endfunction

  function automatic logic [CELLS-1:0] therm(input int c);
    logic [CELLS-1:0] r;
    for (int i = 0; i < CELLS; i++) r[i] = (i >= sat(c));
    return r;
  endfunction

  function automatic logic [CELLS:0] cold(input int c);
    logic [CELLS:0] r;
    for (int i = 0; i <= CELLS; i++) r[i] = (i != sat(c) + 1);
    return r;
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (t_o !== cold(cur)) begin
      fails++;
      $display("FAIL %s/R2/R3 t_o actual=%b expected=%b", tag, t_o, cold(cur));
    end
    checks++;
    if (s_o !== therm(prev)) begin
      fails++;
      $display("FAIL %s/R1/R4 s_o actual=%b expected=%b", tag, s_o, therm(prev));
    end
  endtask

  // At a falling edge: check results of the last rising edge, then drive v.
  task automatic step(input int v, input string tag);
    @(negedge clk);
    check_out(tag);
    prev = cur;
    cur  = v;
    code_i = CODE_W'(v);
  endtask

  initial begin
    void'($urandom(32'd9127));
    code_i = CODE_W'(5);
    repeat (3) @(negedge clk);
    // R5: reset state while reset is held
    checks++;
    if (s_o !== '1 || t_o !== ~((CELLS+1)'(2))) begin
      fails++;
      $display("FAIL R5 reset s_o=%b t_o=%b expected s=%b t=%b",
               s_o, t_o, {CELLS{1'b1}}, ~((CELLS+1)'(2)));
    end
    // R7: tie level for the non-inverting arrangement
    checks++;
    if (tie_o !== 1'b1) begin
      fails++;
      $display("FAIL R7 tie_o actual=%b expected=1", tie_o);
    end
    code_i = '0;
    cur = 0;
    prev = 0;
    rst = 1'b0;
    step(0, "R5 first cycle after reset");
    // R4: multi-step jumps, T must lead S by exactly one cycle
    step(7, "R4 hold");
    step(7, "R4 jump 0->7 T first");
    step(0, "R4 jump 0->7 S next");
    step(0, "R4 jump 7->0 T first");
    step(2, "R4 jump 7->0 S next");
    step(2, "R1 code 2");
    step(5, "R1 code 2 S");
    step(1, "R4 3-step jump");
    step(6, "R4 reversal");
    // R6: out-of-range codes saturate
    step(15, "R4 alt");
    step(8, "R6 code 15");
    step(8, "R6 code 8");
    step(3, "R6 code 8 hold");
    step(3, "R6 leave saturation");
    for (int n = 0; n < 400; n++) begin
      step(int'($urandom_range(0, (1 << CODE_W) - 1)), "R1/R2/R3/R4/R6 random");
    end
    step(0, "R4 drain");
    step(0, "R4 drain");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule